// File: doc/BRIEF.md
# Universal Bidirectional Shift Register

A small register of `WIDTH` bits (four by default) whose behaviour on each rising clock edge is picked by a two-bit mode select. It can keep its contents, move every bit one place toward the right end, move every bit one place toward the left end, or take a whole new word from its parallel input. Each end has a serial input that feeds the vacated end bit during a shift, and a serial output that always shows that end's current bit. The whole word is visible on the parallel output.

Bit index 0 is the leftmost cell and index `WIDTH-1` is the rightmost. A right shift therefore moves data toward higher indices, and a left shift moves it toward lower ones. A parallel load followed by `WIDTH` right shifts sends the word out on the right serial output, rightmost bit first. This is the usual use as a parallel-to-serial converter. A synchronous clear input zeroes the register whatever mode is selected.

Top module: `ushift_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge, all bits become 0 on that edge.
- R2: When `clr` is high at a rising edge and `rst_n` is high, all bits become 0 on that edge for every value of `mode_sel`.
- R3: With `mode_sel` = 2'b00 (and no clear), the register keeps its value.
- R4: With `mode_sel` = 2'b01, bit i takes the old bit i-1 for i ≥ 1, and bit 0 takes `ser_left_in`.
- R5: With `mode_sel` = 2'b10, bit i takes the old bit i+1 for i < WIDTH-1, and bit WIDTH-1 takes `ser_right_in`.
- R6: With `mode_sel` = 2'b11, the register takes `par_in`, where `par_in[i]` goes to bit i.
- R7: `ser_left_out` always equals bit 0 and `ser_right_out` always equals bit WIDTH-1 of `par_out`.
- R8: After a load of word W, the values on `ser_right_out` before each of WIDTH right shifts are W[WIDTH-1], W[WIDTH-2], ..., W[0] in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear, active high, overrides the mode |
| mode_sel | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_left_in | input | 1 | Fill bit for bit 0 on a right shift |
| ser_right_in | input | 1 | Fill bit for bit WIDTH-1 on a left shift |
| par_in | input | WIDTH | Word taken on a load; index 0 is leftmost |
| par_out | output | WIDTH | Current register contents; index 0 is leftmost |
| ser_left_out | output | 1 | Current bit 0 |
| ser_right_out | output | 1 | Current bit WIDTH-1 |

## Verification
On every cycle the assertions check the single-step relation between consecutive register values: zeroing by reset and clear, keeping in hold, the two neighbour moves with their end fills, the load, and the tie of the serial outputs to the end bits. Behaviour that spans many cycles, such as a load followed by a full run of right shifts that serializes the word in order, can only be shown by the bench's directed scenarios. The long random mix of modes, clears and serial fills is compared against a reference model in the bench.

// File: rtl/ushift_pkg.sv
// Package: shared types for the universal shift register.
// Assumes the 2-bit select encoding listed in the brief.
package ushift_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_SHR   = 2'b01,
        MODE_SHL   = 2'b10,
        MODE_LOAD  = 2'b11
    } shift_mode_e;

endpackage

// File: rtl/ushift_mode_dec.sv
// Module: ushift_mode_dec
// Turns the raw select pins into the mode type and merges the reset
// and clear into one zeroing request shared by all cells.
// Assumes rst_n is active low and clr is active high, both synchronous.
module ushift_mode_dec
    import ushift_pkg::*;
(
    input  logic [1:0]  sel_i,
    input  logic        rst_n_i,
    input  logic        clr_i,
    output shift_mode_e mode_o,
    output logic        zero_o
);

    // Purpose: decode select bits and form the zeroing request.
    always_comb begin
        mode_o = shift_mode_e'(sel_i);
        zero_o = !rst_n_i || clr_i;
    end

endmodule

// File: rtl/ushift_cell.sv
// Module: ushift_cell
// One storage bit. A 4:1 selection picks its own value, its left
// neighbour, its right neighbour or its parallel bit as the next value.
// Assumes the zeroing request is already synchronous to clk.
module ushift_cell
    import ushift_pkg::*;
(
    input  logic        clk,
    input  logic        zero_i,
    input  shift_mode_e mode_i,
    input  logic        from_left_i,
    input  logic        from_right_i,
    input  logic        par_i,
    output logic        q_o
);

    logic next_d;

    // Purpose: choose the next bit value from the mode.
    always_comb begin
        unique case (mode_i)
            MODE_HOLD: next_d = q_o;
            MODE_SHR:  next_d = from_left_i;
            MODE_SHL:  next_d = from_right_i;
            MODE_LOAD: next_d = par_i;
            default:   next_d = q_o;
        endcase
    end

    // Purpose: store the bit, zeroing on reset or clear.
    always_ff @(posedge clk) begin
        if (zero_i) q_o <= 1'b0;
        else        q_o <= next_d;
    end

endmodule

// File: rtl/ushift_reg.sv
// Module: ushift_reg (top)
// WIDTH-bit universal shift register: hold, shift right, shift left,
// parallel load, with a synchronous clear that overrides the mode.
// Index 0 is the leftmost bit. Assumes WIDTH >= 2.
module ushift_reg
    import ushift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       mode_sel,
    input  logic             ser_left_in,
    input  logic             ser_right_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out,
    output logic             ser_left_out,
    output logic             ser_right_out
);

    localparam int LAST = WIDTH - 1;

    shift_mode_e      mode;
    logic             zero;
    logic [WIDTH-1:0] bits_q;
    logic [WIDTH-1:0] left_src;
    logic [WIDTH-1:0] right_src;

    ushift_mode_dec u_dec (
        .sel_i   (mode_sel),
        .rst_n_i (rst_n),
        .clr_i   (clr),
        .mode_o  (mode),
        .zero_o  (zero)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        // Neighbour wiring: end cells take the serial inputs.
        if (i == 0) begin : g_lend
            assign left_src[i] = ser_left_in;
        end else begin : g_lmid
            assign left_src[i] = bits_q[i-1];
        end
        if (i == LAST) begin : g_rend
            assign right_src[i] = ser_right_in;
        end else begin : g_rmid
            assign right_src[i] = bits_q[i+1];
        end

        ushift_cell u_cell (
            .clk          (clk),
            .zero_i       (zero),
            .mode_i       (mode),
            .from_left_i  (left_src[i]),
            .from_right_i (right_src[i]),
            .par_i        (par_in[i]),
            .q_o          (bits_q[i])
        );
    end

    // Purpose: drive the parallel and serial outputs from the cells.
    always_comb begin
        par_out       = bits_q;
        ser_left_out  = bits_q[0];
        ser_right_out = bits_q[LAST];
    end

endmodule

// File: rtl/ushift_reg_chk.sv
// Module: ushift_reg_chk
// Cycle-by-cycle property checker for ushift_reg, bound to the top.
// Keeps one cycle of input history to relate consecutive outputs.
module ushift_reg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic [1:0]       mode_sel,
    input logic             ser_left_in,
    input logic             ser_right_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] par_out,
    input logic             ser_left_out,
    input logic             ser_right_out
);

    logic             live_q;
    logic [1:0]       sel_q;
    logic             sli_q;
    logic             sri_q;
    logic [WIDTH-1:0] pin_q;
    logic [WIDTH-1:0] out_q;

    // Purpose: remember last cycle's inputs and outputs.
    always_ff @(posedge clk) begin
        live_q <= rst_n && !clr;
        sel_q  <= mode_sel;
        sli_q  <= ser_left_in;
        sri_q  <= ser_right_in;
        pin_q  <= par_in;
        out_q  <= par_out;
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> par_out == '0);

    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> par_out == '0);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !clr && mode_sel == 2'b00) |=> $stable(par_out));

    assert_shift_right_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && sel_q == 2'b01) |-> par_out == {out_q[WIDTH-2:0], sli_q});

    assert_shift_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && sel_q == 2'b10) |-> par_out == {sri_q, out_q[WIDTH-1:1]});

    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && sel_q == 2'b11) |-> par_out == pin_q);

    assert_serial_taps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ser_left_out == par_out[0] && ser_right_out == par_out[WIDTH-1]);

endmodule

bind ushift_reg ushift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (clr),
    .mode_sel      (mode_sel),
    .ser_left_in   (ser_left_in),
    .ser_right_in  (ser_right_in),
    .par_in        (par_in),
    .par_out       (par_out),
    .ser_left_out  (ser_left_out),
    .ser_right_out (ser_right_out)
);

// File: tb/test_ushift_reg.sv
// Bench for ushift_reg: directed corner cases plus a seeded random
// stream of modes, compared against a bench reference model.
module test_ushift_reg;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic [1:0]   mode_sel = 2'b00;
    logic         ser_left_in = 1'b0;
    logic         ser_right_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] par_out;
    logic         ser_left_out;
    logic         ser_right_out;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] model = '0;

    always #10 clk = ~clk;   // 50 MHz

    ushift_reg #(.WIDTH(W)) i_ushift_reg (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mode_sel(mode_sel),
        .ser_left_in(ser_left_in), .ser_right_in(ser_right_in),
        .par_in(par_in), .par_out(par_out),
        .ser_left_out(ser_left_out), .ser_right_out(ser_right_out)
    );

    // Reference next state from the requirements (index 0 leftmost).
    function automatic logic [W-1:0] ref_next(logic [W-1:0] cur, logic rn,
            logic cl, logic [1:0] s, logic sli, logic sri, logic [W-1:0] pin);
        logic [W-1:0] n;
        if (!rn || cl) return '0;
        n = cur;
        case (s)
            2'b01: begin
                for (int i = W-1; i > 0; i--) n[i] = cur[i-1];
                n[0] = sli;
            end
            2'b10: begin
                for (int i = 0; i < W-1; i++) n[i] = cur[i+1];
                n[W-1] = sri;
            end
            2'b11: n = pin;
            default: n = cur;
        endcase
        return n;
    endfunction

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Apply inputs, clock once, then check outputs at the falling edge.
    task automatic step(string req, logic rn, logic cl, logic [1:0] s,
            logic sli, logic sri, logic [W-1:0] pin);
        rst_n = rn; clr = cl; mode_sel = s;
        ser_left_in = sli; ser_right_in = sri; par_in = pin;
        @(posedge clk);
        @(negedge clk);
        model = ref_next(model, rn, cl, s, sli, sri, pin);
        check(req, par_out, model);
        check("R7", {ser_left_out, ser_right_out}, {model[0], model[W-1]});
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] word;
        logic [W-1:0] got;
        void'($urandom(32'd7731));
        @(negedge clk);
        // R1: reset state
        step("R1", 1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 4'b1111);
        // R6: load, then R3 hold ignores serial and parallel inputs
        step("R6", 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 4'b1011);
        step("R3", 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 4'b0000);
        // R4: right shift with a fill of 1, then 0
        step("R4", 1'b1, 1'b0, 2'b01, 1'b1, 1'b0, 4'b0000);
        step("R4", 1'b1, 1'b0, 2'b01, 1'b0, 1'b1, 4'b0000);
        // R5: left shift with fills
        step("R5", 1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 4'b0000);
        step("R5", 1'b1, 1'b0, 2'b10, 1'b1, 1'b0, 4'b0000);
        // R2: clear wins over every mode
        for (int s = 0; s < 4; s++) begin
            step("R6", 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 4'b1111);
            step("R2", 1'b1, 1'b1, 2'(s), 1'b1, 1'b1, 4'b1111);
        end
        // R1: reset also wins over load
        step("R6", 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, 4'b0110);
        step("R1", 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 4'b1001);
        // R8: parallel-to-serial conversion, rightmost bit first
        word = 4'b1101;
        step("R6", 1'b1, 1'b0, 2'b11, 1'b0, 1'b0, word);
        got = '0;
        for (int k = 0; k < W; k++) begin
            got[W-1-k] = ser_right_out;
            step("R4", 1'b1, 1'b0, 2'b01, 1'b0, 1'b0, 4'b0000);
        end
        check("R8", got, word);
        // Random mix of modes, fills, clears and occasional resets
        for (int n = 0; n < 400; n++) begin
            logic rn;
            logic cl;
            rn = ($urandom % 32) != 0;
            cl = ($urandom % 10) == 0;
            step("R3-R6 random", rn, cl, 2'($urandom), 1'($urandom),
                 1'($urandom), W'($urandom));
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule